// File: doc/BRIEF.md
# Indirect Jump Target Fetch Sequencer

This block is the bus-master part of an 8-bit CPU's indirect jump. A start strobe marks the cycle in which the jump opcode sits on the bus at address `pc_i`. The sequencer then takes over the synchronous read port. It reads a two-byte pointer from the instruction stream, and then reads the two bytes of the jump target from the location the pointer names. When it has both bytes, it pulses `done_o` with the new program counter and the number of cycles the jump took.

A mode input chooses how the second target byte is addressed when the pointer's low byte is 0xFF. In page-wrap mode, only the low byte of the pointer is incremented, so the second read stays in the same 256-byte page and no extra cycle is spent. In carry mode, the whole 16-bit pointer is incremented and one internal cycle is always added, whatever the pointer value, so the timing in that mode never varies. The mode is captured together with the start strobe.

The memory answers one clock after an address is presented. The sequencer presents each address for exactly one cycle with the read strobe high.

Top module: `ind_jump_seq`

## Requirements
- R1: After a synchronous active-low reset, `busy_o`, `done_o` and `mem_rd_o` are all low.
- R2: The pointer is read little-endian. Its low byte is read at `pc_i`+1 in the first cycle after the start cycle, and its high byte at `pc_i`+2 in the next cycle. The read strobe is high in both cycles.
- R3: In the third cycle after start, the target low byte is read at the full pointer address {pointer high, pointer low}.
- R4: In page-wrap mode (`mode_fix_i`=0), the target high byte is read in the fourth cycle after start, at {pointer high, (pointer low + 1) mod 256}. Pointer 0x19FF reads 0x19FF and then 0x1900.
- R5: In carry mode (`mode_fix_i`=1), the target high byte is read in the fifth cycle after start, at the 16-bit pointer + 1 (mod 65536). Pointer 0x19FF reads 0x19FF and then 0x2000.
- R6: In page-wrap mode, `done_o` rises 5 cycles after the start cycle, and `cyc_cnt_o` equals 5 in that cycle.
- R7: In carry mode, the fourth cycle after start is an internal cycle with the read strobe low. `done_o` rises 6 cycles after start and `cyc_cnt_o` equals 6, for every pointer value, including low bytes other than 0xFF.
- R8: `done_o` is high for exactly one cycle. In that cycle `pc_new_o` = {byte read at the high address, byte read at the pointer address}. `busy_o` is low in the following cycle.
- R9: A start strobe while `busy_o` is high has no effect: the addresses, the result and the cycle count of the running jump are unchanged, and no new jump begins after it.
- R10: `mode_fix_i` is sampled only in the start cycle. Changing it during a jump does not change that jump's addresses or timing.
- R11: The read strobe is asserted only while `busy_o` is high. Read data is taken one clock after its address was presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Jump opcode cycle strobe; ignored while busy |
| mode_fix_i | input | 1 | 1 = carry mode, 0 = page-wrap mode; sampled with start |
| pc_i | input | 16 | Address of the jump opcode; sampled with start |
| mem_addr_o | output | 16 | Read address |
| mem_rd_o | output | 1 | Read strobe |
| mem_data_i | input | 8 | Read data, valid one clock after its address |
| busy_o | output | 1 | Jump in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pc_new_o | output | 16 | New program counter, valid with done_o |
| cyc_cnt_o | output | 4 | Cycles taken, start cycle included, valid with done_o |

## Verification
Some properties are checked by assertions on every cycle. These cover the relations between consecutive bus addresses: the pointer bytes are read at adjacent addresses, the page-wrap high read stays in the page of the low read, and the carry-mode high read is the low-read address plus one. They also cover the silent internal cycle, the single-cycle done pulse, a cycle count that matches the captured mode, and a mode that holds steady while busy. Only the bench scenarios can show that the data returned by memory ends up in the right byte of `pc_new_o`, that the 0x19FF and 0xFFFF pointers give the expected targets, and that a mid-jump start strobe or mode change leaves the whole jump, its result and its timing unaltered.

// File: rtl/ijs_pkg.sv
// Package: shared state encoding for the indirect jump sequencer.
// Assumes: one state per bus cycle of the jump.
package ijs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PTR_LO,
        ST_PTR_HI,
        ST_TGT_LO,
        ST_GAP,
        ST_TGT_HI,
        ST_DONE
    } ijs_state_t;
endpackage

// File: rtl/ijs_hi_addr.sv
// Module: ijs_hi_addr
// Forms the address of the target high byte from the pointer.
// carry_en=0 increments only the low byte, so the read wraps within the page.
// carry_en=1 increments the whole pointer, so the carry reaches the page byte.
// Assumes: the pointer bytes are stable while the result is used.
module ijs_hi_addr #(
    parameter int DW = 8
) (
    input  logic [DW-1:0]   ptr_lo,
    input  logic [DW-1:0]   ptr_hi,
    input  logic            carry_en,
    output logic [2*DW-1:0] hi_addr
);
    localparam int AW = 2 * DW;

    logic [AW-1:0] full_inc;
    logic [DW-1:0] lo_inc;

    // Both candidate increments are computed; the mode selects one.
    always_comb begin
        full_inc = {ptr_hi, ptr_lo} + AW'(1);
        lo_inc   = ptr_lo + DW'(1);
        hi_addr  = carry_en ? full_inc : {ptr_hi, lo_inc};
    end
endmodule

// File: rtl/ijs_cycle_ctr.sv
// Module: ijs_cycle_ctr
// Counts the bus cycles of one jump. load sets the count to 1, which
// counts the opcode cycle; inc adds one for each later cycle.
// Assumes: load and inc are never high together.
module ijs_cycle_ctr #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          inc,
    output logic [CW-1:0] count
);
    // Count register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n)    count <= '0;
        else if (load) count <= CW'(1);
        else if (inc)  count <= count + CW'(1);
    end
endmodule

// File: rtl/ind_jump_seq.sv
// Module: ind_jump_seq
// Bus-master sequencer for an indirect jump. It reads the pointer at pc+1
// and pc+2, then reads the target low and high bytes through the pointer.
// It pulses done with the new PC and the cycle count.
// Assumes: a synchronous memory whose data is valid one clock after the
// address; the start cycle is the opcode cycle.
module ind_jump_seq
    import ijs_pkg::*;
#(
    parameter int DW = 8,
    parameter int CW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            mode_fix_i,
    input  logic [2*DW-1:0] pc_i,
    output logic [2*DW-1:0] mem_addr_o,
    output logic            mem_rd_o,
    input  logic [DW-1:0]   mem_data_i,
    output logic            busy_o,
    output logic            done_o,
    output logic [2*DW-1:0] pc_new_o,
    output logic [CW-1:0]   cyc_cnt_o
);
    localparam int AW = 2 * DW;
    localparam logic [CW-1:0] CNT_WRAP = CW'(5);
    localparam logic [CW-1:0] CNT_FIX  = CW'(6);

    ijs_state_t    state, state_nx;
    logic [AW-1:0] pc_q, last_pc_q, hi_addr;
    logic [DW-1:0] ptr_lo_q, ptr_hi_q, tgt_lo_q;
    logic          mode_q, accept;

    assign busy_o = (state != ST_IDLE);
    assign done_o = (state == ST_DONE);
    assign accept = start_i && !busy_o;

    ijs_hi_addr #(.DW(DW)) u_hi_addr (
        .ptr_lo   (ptr_lo_q),
        .ptr_hi   (ptr_hi_q),
        .carry_en (mode_q),
        .hi_addr  (hi_addr)
    );

    ijs_cycle_ctr #(.CW(CW)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .inc   (busy_o && !done_o),
        .count (cyc_cnt_o)
    );

    // Next-state logic: one state per bus cycle.
    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE:   if (accept) state_nx = ST_PTR_LO;
            ST_PTR_LO: state_nx = ST_PTR_HI;
            ST_PTR_HI: state_nx = ST_TGT_LO;
            ST_TGT_LO: state_nx = mode_q ? ST_GAP : ST_TGT_HI;
            ST_GAP:    state_nx = ST_TGT_HI;
            ST_TGT_HI: state_nx = ST_DONE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // Bus outputs; the target low address takes the pointer high byte
    // straight from the read data that arrives in this cycle.
    always_comb begin
        mem_addr_o = '0;
        mem_rd_o   = 1'b0;
        case (state)
            ST_PTR_LO: begin mem_addr_o = pc_q + AW'(1); mem_rd_o = 1'b1; end
            ST_PTR_HI: begin mem_addr_o = pc_q + AW'(2); mem_rd_o = 1'b1; end
            ST_TGT_LO: begin mem_addr_o = {mem_data_i, ptr_lo_q}; mem_rd_o = 1'b1; end
            ST_GAP:    mem_addr_o = hi_addr;
            ST_TGT_HI: begin mem_addr_o = hi_addr; mem_rd_o = 1'b1; end
            ST_DONE:   mem_addr_o = hi_addr;
            default:   mem_addr_o = '0;
        endcase
    end

    assign pc_new_o = done_o ? {mem_data_i, tgt_lo_q} : last_pc_q;

    // State register, start capture and read-data capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            pc_q      <= '0;
            mode_q    <= 1'b0;
            ptr_lo_q  <= '0;
            ptr_hi_q  <= '0;
            tgt_lo_q  <= '0;
            last_pc_q <= '0;
        end else begin
            state <= state_nx;
            if (accept) begin
                pc_q   <= pc_i;
                mode_q <= mode_fix_i;
            end
            case (state)
                ST_PTR_HI: ptr_lo_q <= mem_data_i;
                ST_TGT_LO: ptr_hi_q <= mem_data_i;
                ST_GAP:    tgt_lo_q <= mem_data_i;
                ST_TGT_HI: if (!mode_q) tgt_lo_q <= mem_data_i;
                ST_DONE:   last_pc_q <= {mem_data_i, tgt_lo_q};
                default:   ;
            endcase
        end
    end

    // ---------------- assertions ----------------
    assert_ptr_adjacent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PTR_HI) |-> (mem_addr_o == $past(mem_addr_o) + AW'(1)));

    assert_wrap_same_page_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TGT_HI && !mode_q) |->
        (mem_addr_o[AW-1:DW] == $past(mem_addr_o[AW-1:DW]) &&
         mem_addr_o[DW-1:0] == DW'($past(mem_addr_o[DW-1:0]) + DW'(1))));

    assert_carry_next_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TGT_HI && mode_q) |-> (mem_addr_o == $past(mem_addr_o, 2) + AW'(1)));

    assert_count_matches_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cyc_cnt_o == (mode_q ? CNT_FIX : CNT_WRAP)));

    assert_gap_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GAP) |-> (!mem_rd_o && mode_q));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_busy_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> (state != ST_PTR_LO));

    assert_mode_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(mode_q));

    assert_rd_only_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |-> busy_o);
endmodule

// File: tb/ind_jump_seq_bench.sv
// Directed bench for ind_jump_seq: one task per scenario, each self-checking.
module ind_jump_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        mode_fix_i = 1'b0;
    logic [15:0] pc_i = '0;
    logic [15:0] mem_addr_o;
    logic        mem_rd_o;
    logic [7:0]  mem_data_i;
    logic        busy_o, done_o;
    logic [15:0] pc_new_o;
    logic [3:0]  cyc_cnt_o;

    int checks = 0;
    int errors = 0;

    logic [15:0] pc_v = 16'h0400;
    logic [15:0] ptr_v = 16'h0000;

    always #10 clk = ~clk;

    ind_jump_seq u_ind_jump_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_fix_i(mode_fix_i),
        .pc_i(pc_i), .mem_addr_o(mem_addr_o), .mem_rd_o(mem_rd_o),
        .mem_data_i(mem_data_i), .busy_o(busy_o), .done_o(done_o),
        .pc_new_o(pc_new_o), .cyc_cnt_o(cyc_cnt_o)
    );

    function automatic logic [7:0] hashb(input logic [15:0] a);
        return a[7:0] ^ {a[14:8], a[15]} ^ 8'h3C;
    endfunction

    function automatic logic [7:0] memf(input logic [15:0] a);
        if (a == pc_v + 16'd1) return ptr_v[7:0];
        if (a == pc_v + 16'd2) return ptr_v[15:8];
        return hashb(a);
    endfunction

    // Synchronous memory: data one clock after the address.
    always_ff @(posedge clk) mem_data_i <= memf(mem_addr_o);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One jump; poke = start strobe while busy, flip = mode change while busy.
    task automatic run_jump(input logic [15:0] pc, input logic [15:0] ptr, input bit fix,
                            input bit poke, input bit flip);
        logic [15:0] hi_a, exp_pc;
        int exp_n, done_at;
        logic [15:0] got_pc;
        logic [3:0]  got_cnt;
        pc_v = pc; ptr_v = ptr;
        hi_a = fix ? ptr + 16'd1 : {ptr[15:8], 8'(ptr[7:0] + 8'd1)};
        exp_pc = {hashb(hi_a), hashb(ptr)};
        exp_n = fix ? 6 : 5;
        done_at = 0; got_pc = '0; got_cnt = '0;
        @(negedge clk);
        pc_i = pc; mode_fix_i = fix; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 1; i <= 8; i++) begin
            if (done_o) begin
                done_at = i; got_pc = pc_new_o; got_cnt = cyc_cnt_o;
                break;
            end
            if (i == 1) chk(mem_rd_o && mem_addr_o == pc + 16'd1, "R2 ptr lo addr", mem_addr_o, pc + 16'd1);
            if (i == 2) chk(mem_rd_o && mem_addr_o == pc + 16'd2, "R2 ptr hi addr", mem_addr_o, pc + 16'd2);
            if (i == 3) chk(mem_rd_o && mem_addr_o == ptr, "R3 target lo addr", mem_addr_o, ptr);
            if (i == 4 && !fix) chk(mem_rd_o && mem_addr_o == hi_a, "R4 wrap hi addr", mem_addr_o, hi_a);
            if (i == 4 && fix)  chk(!mem_rd_o, "R7 internal cycle strobe", mem_rd_o, 0);
            if (i == 5 && fix)  chk(mem_rd_o && mem_addr_o == hi_a, "R5 carry hi addr", mem_addr_o, hi_a);
            chk(!mem_rd_o || busy_o, "R11 strobe only while busy", mem_rd_o, busy_o);
            if (flip && i == 1) mode_fix_i = !fix;
            if (poke && i == 2) begin start_i = 1'b1; mode_fix_i = !fix; pc_i = pc ^ 16'h00F0; end
            if (poke && i == 3) start_i = 1'b0;
            @(negedge clk);
        end
        chk(done_at == exp_n, fix ? "R7 done latency" : "R6 done latency", done_at, exp_n);
        chk(got_cnt == 4'(exp_n), fix ? "R7 cycle count" : "R6 cycle count", got_cnt, exp_n);
        chk(got_pc == exp_pc, "R8 new pc", got_pc, exp_pc);
        @(negedge clk);
        chk(!done_o && !busy_o, "R8 done single pulse, idle after", {done_o, busy_o}, 0);
        if (poke) begin
            @(negedge clk);
            chk(!busy_o && !mem_rd_o, "R9 no restart after busy start", {busy_o, mem_rd_o}, 0);
        end
        mode_fix_i = 1'b0;
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(!busy_o && !done_o && !mem_rd_o, "R1 reset state", {busy_o, done_o, mem_rd_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o, "R1 idle after reset", busy_o, 0);
    endtask

    task automatic test_wrap_boundary();   run_jump(16'h0400, 16'h19FF, 1'b0, 1'b0, 1'b0); endtask
    task automatic test_carry_boundary();  run_jump(16'h0400, 16'h19FF, 1'b1, 1'b0, 1'b0); endtask
    task automatic test_wrap_plain();      run_jump(16'h0810, 16'h1234, 1'b0, 1'b0, 1'b0); endtask
    task automatic test_carry_plain();     run_jump(16'h0810, 16'h1234, 1'b1, 1'b0, 1'b0); endtask
    task automatic test_carry_top();       run_jump(16'h0300, 16'hFFFF, 1'b1, 1'b0, 1'b0); endtask
    task automatic test_wrap_top();        run_jump(16'h0300, 16'hFFFF, 1'b0, 1'b0, 1'b0); endtask
    task automatic test_start_while_busy(); run_jump(16'h0500, 16'h33FF, 1'b0, 1'b1, 1'b0); endtask
    task automatic test_mode_flip_fix();   run_jump(16'h0600, 16'h44FF, 1'b1, 1'b0, 1'b1); endtask // R10
    task automatic test_mode_flip_wrap();  run_jump(16'h0600, 16'h45FF, 1'b0, 1'b0, 1'b1); endtask // R10
    task automatic test_pc_page_edge();    run_jump(16'h06FF, 16'h2080, 1'b1, 1'b0, 1'b0); endtask

    initial begin
        test_reset();
        test_wrap_boundary();
        test_carry_boundary();
        test_wrap_plain();
        test_carry_plain();
        test_carry_top();
        test_wrap_top();
        test_start_while_busy();
        test_mode_flip_fix();
        test_mode_flip_wrap();
        test_pc_page_edge();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule